// File: doc/BRIEF.md
# DPLL Lock Status Monitor

This block watches the reference clocks feeding a digital PLL and the loop's raw phase-in-tolerance signal. It keeps a read-only 8-bit status word that reports five conditions:
- whether the selected reference is toggling,
- whether lock has been lost or never reached,
- whether the loop is locked,
- whether a holdover history is available,
- whether a fresh holdover history has just been built and made active.

The block does not contain the phase detector, the loop filter, the holdover averaging or the policy that picks a reference.

Each of the four references is monitored all the time through its own synchronizer and idle-window counter, so changing the select shows the new reference's state at once. Lock is declared only after the tolerance signal has stayed high for a set number of cycles. Loss of lock is raised in two cases: when lock is not reached within a time limit, and when an established lock drops. An automatic reference switch restarts the timing and hides loss-of-lock reporting until the loop requalifies or the limit runs out.

Top module: `dpll_lock_monitor`

## Requirements
- R1: `status` layout: bit 0 is loss of signal, bit 1 is loss of lock, bit 2 is locked, bit 3 is holdover available, bit 4 is holdover build complete. Bits 7..5 always read 0. Every bit is 0 after reset.
- R2: Each reference input passes through a two-stage synchronizer followed by an edge detector. A rising edge sampled at clock edge k clears that reference's loss-of-signal flag at edge k+2. The flag sets once ACT_WIN consecutive clocks pass with no detected rising edge.
- R3: Bit 0 shows, in the same cycle, the flag of the reference picked by `ref_sel`. Value 0 selects reference 1 (`ref_in[0]`) and value 3 selects reference 4 (`ref_in[3]`).
- R4: Bit 2 sets at the clock edge on which `phase_ok` has been sampled high for LOCK_QUAL consecutive edges. The count restarts from zero after reset, after a low sample and after an automatic switch.
- R5: Bit 2 clears at the first edge that samples `phase_ok` low.
- R6: If bit 2 is set and `phase_ok` is sampled low, bit 1 sets at that edge unless masking is active (R9).
- R7: Bit 1 sets when LOCK_TMO consecutive edges pass without lock qualification. The count restarts on reset, on qualification and on an automatic switch.
- R8: Bit 1 clears at the edge on which lock qualification is reached, and is otherwise sticky.
- R9: An `auto_switch` pulse does the following:
  - restarts both the qualification count and the timeout count;
  - leaves bit 2 set if `phase_ok` stays high;
  - never sets bit 1 in its own cycle;
  - masks loss-of-lock reporting on a lock drop until qualification is reached again or the timeout fires.
- R10: Bit 3 sets on a `hist_done` pulse and clears on a `hist_flush` pulse.
- R11: Bit 4 sets on `hist_done` and clears on `hist_start`. If both come in the same cycle, `hist_done` wins.
- R12: `hist_flush` takes priority over `hist_done` and `hist_start`. It clears bits 3 and 4 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | NUM_REF (4) | Asynchronous reference clock inputs, bit 0 = reference 1 |
| ref_sel | input | SEL_W (2) | Index of the active reference |
| phase_ok | input | 1 | Raw phase-in-tolerance indication from the loop |
| auto_switch | input | 1 | One-cycle pulse marking an automatic reference switch |
| hist_start | input | 1 | Pulse: a new holdover history build begins |
| hist_done | input | 1 | Pulse: a new history has been built and made active |
| hist_flush | input | 1 | Pulse: the holdover history has been discarded |
| status | output | 8 | Status word as laid out in R1 |

## Verification
The case of interest is a lock drop and an automatic switch landing on the same clock edge. The unmasked lock-drop path would set loss of lock, while the switch must suppress it. The bench provokes this in a directed step: `auto_switch` is asserted in the same cycle that `phase_ok` falls while locked. Random traffic then repeats the coincidence with switches and tolerance drops. Every edge is judged against a behavioural model in which the switch's mask takes effect in its own cycle; a second directed step confirms that, once the mask has lifted, a later drop is reported.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

    localparam int unsigned DLM_NUM_REF       = 4;
    localparam int unsigned DLM_ACT_WIN_DEF   = 16;
    localparam int unsigned DLM_LOCK_QUAL_DEF = 8;
    localparam int unsigned DLM_LOCK_TMO_DEF  = 4096;

    // Status word seen at the top-level output
    typedef struct packed {
        logic [2:0] rsvd;
        logic       hold_built;
        logic       hold_avail;
        logic       locked;
        logic       lol;
        logic       los;
    } dlm_status_t;

    // Lock tracker flags
    typedef struct packed {
        logic locked;
        logic lol;
        logic mask;
    } dlm_lock_t;

    // Holdover strobe decode, highest priority first
    typedef enum logic [1:0] {
        HIST_IDLE  = 2'd0,
        HIST_START = 2'd1,
        HIST_DONE  = 2'd2,
        HIST_FLUSH = 2'd3
    } dlm_hist_cmd_e;

    function automatic dlm_hist_cmd_e dlm_hist_decode(
        input logic start_p,
        input logic done_p,
        input logic flush_p
    );
        if (flush_p)      return HIST_FLUSH;
        else if (done_p)  return HIST_DONE;
        else if (start_p) return HIST_START;
        else              return HIST_IDLE;
    endfunction

endpackage

// File: rtl/dlm_ref_activity.sv
module dlm_ref_activity
    import dlm_pkg::*;
#(
    parameter int unsigned ACT_WIN = DLM_ACT_WIN_DEF,
    localparam int unsigned CW = (ACT_WIN > 1) ? $clog2(ACT_WIN) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_async,
    output logic los
);

    logic          sync_a, sync_b, sync_c;
    logic          rise;
    logic [CW-1:0] idle_q;
    logic          los_q;

    // Two-stage synchronizer plus one stage for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
            sync_c <= 1'b0;
        end else begin
            sync_a <= ref_async;
            sync_b <= sync_a;
            sync_c <= sync_b;
        end
    end

    assign rise = sync_b & ~sync_c;

    // Idle window: count clocks since the last detected rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q <= '0;
            los_q  <= 1'b0;
        end else if (rise) begin
            idle_q <= '0;
            los_q  <= 1'b0;
        end else if (idle_q == CW'(ACT_WIN - 1)) begin
            los_q  <= 1'b1;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign los = los_q;

endmodule

// File: rtl/dlm_lock_tracker.sv
module dlm_lock_tracker
    import dlm_pkg::*;
#(
    parameter int unsigned LOCK_QUAL = DLM_LOCK_QUAL_DEF,
    parameter int unsigned LOCK_TMO  = DLM_LOCK_TMO_DEF,
    localparam int unsigned QW = $clog2(LOCK_QUAL + 1),
    localparam int unsigned TW = (LOCK_TMO > 1) ? $clog2(LOCK_TMO) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic phase_ok,
    input  logic auto_switch,
    output logic locked,
    output logic lol
);

    logic [QW-1:0] qual_q, qual_d;
    logic [TW-1:0] tmo_q, tmo_d;
    dlm_lock_t     st_q, st_d;
    logic          qualified;
    logic          lock_drop;
    logic          mask_eff;
    logic          tmo_fire;

    // Qualification counter: consecutive high samples, saturating
    always_comb begin
        if (auto_switch || !phase_ok)
            qual_d = '0;
        else if (qual_q == QW'(LOCK_QUAL))
            qual_d = qual_q;
        else
            qual_d = qual_q + 1'b1;
    end

    assign qualified = (qual_d == QW'(LOCK_QUAL));
    assign lock_drop = st_q.locked && !phase_ok;
    assign mask_eff  = st_q.mask || auto_switch;
    assign tmo_fire  = !auto_switch && !qualified && (tmo_q == TW'(LOCK_TMO - 1));

    // Timeout counter: clocks without qualification, saturating
    always_comb begin
        if (auto_switch || qualified)
            tmo_d = '0;
        else if (tmo_fire)
            tmo_d = tmo_q;
        else
            tmo_d = tmo_q + 1'b1;
    end

    // Flag update
    always_comb begin
        st_d        = st_q;
        st_d.locked = phase_ok && (st_q.locked || qualified);
        if (qualified)
            st_d.lol = 1'b0;
        else if (tmo_fire)
            st_d.lol = 1'b1;
        else if (lock_drop && !mask_eff)
            st_d.lol = 1'b1;
        if (auto_switch)
            st_d.mask = 1'b1;
        else if (qualified || tmo_fire)
            st_d.mask = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qual_q <= '0;
            tmo_q  <= '0;
            st_q   <= '0;
        end else begin
            qual_q <= qual_d;
            tmo_q  <= tmo_d;
            st_q   <= st_d;
        end
    end

    assign locked = st_q.locked;
    assign lol    = st_q.lol;

endmodule

// File: rtl/dlm_holdover_flags.sv
module dlm_holdover_flags
    import dlm_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hist_start,
    input  logic hist_done,
    input  logic hist_flush,
    output logic avail,
    output logic built
);

    dlm_hist_cmd_e cmd;
    logic          avail_q, built_q;

    assign cmd = dlm_hist_decode(hist_start, hist_done, hist_flush);

    always_ff @(posedge clk) begin
        if (rst) begin
            avail_q <= 1'b0;
            built_q <= 1'b0;
        end else begin
            case (cmd)
                HIST_FLUSH: begin
                    avail_q <= 1'b0;
                    built_q <= 1'b0;
                end
                HIST_DONE: begin
                    avail_q <= 1'b1;
                    built_q <= 1'b1;
                end
                HIST_START: built_q <= 1'b0;
                default: ;
            endcase
        end
    end

    assign avail = avail_q;
    assign built = built_q;

endmodule

// File: rtl/dpll_lock_monitor.sv
module dpll_lock_monitor
    import dlm_pkg::*;
#(
    parameter int unsigned NUM_REF   = DLM_NUM_REF,
    parameter int unsigned ACT_WIN   = DLM_ACT_WIN_DEF,
    parameter int unsigned LOCK_QUAL = DLM_LOCK_QUAL_DEF,
    parameter int unsigned LOCK_TMO  = DLM_LOCK_TMO_DEF,
    localparam int unsigned SEL_W = (NUM_REF > 1) ? $clog2(NUM_REF) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REF-1:0] ref_in,
    input  logic [SEL_W-1:0]   ref_sel,
    input  logic               phase_ok,
    input  logic               auto_switch,
    input  logic               hist_start,
    input  logic               hist_done,
    input  logic               hist_flush,
    output logic [7:0]         status
);

    localparam bit SEL_FULL = ((1 << SEL_W) == NUM_REF);

    logic [NUM_REF-1:0] los_vec;
    logic               los_sel;
    logic               locked, lol;
    logic               avail, built;
    dlm_status_t        stat;

    for (genvar g = 0; g < NUM_REF; g++) begin : g_ref
        dlm_ref_activity #(.ACT_WIN(ACT_WIN)) u_act (
            .clk       (clk),
            .rst       (rst),
            .ref_async (ref_in[g]),
            .los       (los_vec[g])
        );
    end

    // Select the active reference's flag; out-of-range selects read as no signal
    if (SEL_FULL) begin : g_sel_full
        assign los_sel = los_vec[ref_sel];
    end else begin : g_sel_part
        always_comb begin
            los_sel = 1'b1;
            for (int i = 0; i < NUM_REF; i++)
                if (ref_sel == SEL_W'(i)) los_sel = los_vec[i];
        end
    end

    dlm_lock_tracker #(
        .LOCK_QUAL (LOCK_QUAL),
        .LOCK_TMO  (LOCK_TMO)
    ) u_lock (
        .clk         (clk),
        .rst         (rst),
        .phase_ok    (phase_ok),
        .auto_switch (auto_switch),
        .locked      (locked),
        .lol         (lol)
    );

    dlm_holdover_flags u_hold (
        .clk        (clk),
        .rst        (rst),
        .hist_start (hist_start),
        .hist_done  (hist_done),
        .hist_flush (hist_flush),
        .avail      (avail),
        .built      (built)
    );

    always_comb begin
        stat            = '0;
        stat.los        = los_sel;
        stat.lol        = lol;
        stat.locked     = locked;
        stat.hold_avail = avail;
        stat.hold_built = built;
    end

    assign status = stat;

endmodule

// File: rtl/dlm_checker.sv
module dlm_checker (
    input logic       clk,
    input logic       rst,
    input logic       phase_ok,
    input logic       auto_switch,
    input logic       hist_start,
    input logic       hist_done,
    input logic       hist_flush,
    input logic [7:0] status
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[7:5] == 3'b000); // R1

    AST_LOCK_NEEDS_PHASE: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> $past(phase_ok)); // R4

    AST_LOCK_DROPS: assert property (@(posedge clk) disable iff (rst)
        status[2] && !phase_ok |=> !status[2]); // R5

    AST_LOL_CLEARS_ON_LOCK: assert property (@(posedge clk) disable iff (rst)
        $rose(status[2]) |-> !status[1]); // R8

    AST_SWITCH_NO_LOL: assert property (@(posedge clk) disable iff (rst)
        auto_switch && !status[1] |=> !status[1]); // R9

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (rst)
        hist_done && !hist_flush |=> status[4:3] == 2'b11); // R11

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hist_start && !hist_done && !hist_flush |=> !status[4]); // R11

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hist_flush |=> status[4:3] == 2'b00); // R12

endmodule

bind dpll_lock_monitor dlm_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_ok    (phase_ok),
    .auto_switch (auto_switch),
    .hist_start  (hist_start),
    .hist_done   (hist_done),
    .hist_flush  (hist_flush),
    .status      (status)
);

// File: tb/sim_dpll_lock_monitor.sv
module sim_dpll_lock_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int W  = 12;
    localparam int Q  = 6;
    localparam int TM = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ref_in = '0;
    logic [1:0] ref_sel = '0;
    logic       phase_ok = 1'b0;
    logic       auto_switch = 1'b0;
    logic       hist_start = 1'b0;
    logic       hist_done = 1'b0;
    logic       hist_flush = 1'b0;
    logic [7:0] status;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int hp[4] = '{3, 5, 0, 20};

    dpll_lock_monitor #(
        .NUM_REF(4), .ACT_WIN(W), .LOCK_QUAL(Q), .LOCK_TMO(TM)
    ) u0 (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ref_sel(ref_sel),
        .phase_ok(phase_ok), .auto_switch(auto_switch),
        .hist_start(hist_start), .hist_done(hist_done), .hist_flush(hist_flush),
        .status(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    int  m_d1[4], m_d2[4], m_d3[4], m_idle[4];
    bit  m_los[4];
    int  m_q, m_t;
    bit  m_locked, m_lol, m_mask, m_avail, m_built;
    bit  armed = 0;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_d1[i] = 0; m_d2[i] = 0; m_d3[i] = 0; m_idle[i] = 0; m_los[i] = 0;
            end
            m_q = 0; m_t = 0;
            m_locked = 0; m_lol = 0; m_mask = 0; m_avail = 0; m_built = 0;
        end else begin
            bit qual, drop, tout;
            for (int i = 0; i < 4; i++) begin
                if (m_d2[i] == 1 && m_d3[i] == 0) begin
                    m_idle[i] = 0; m_los[i] = 0;
                end else begin
                    if (m_idle[i] < W) m_idle[i]++;
                    if (m_idle[i] >= W) m_los[i] = 1;
                end
                m_d3[i] = m_d2[i]; m_d2[i] = m_d1[i]; m_d1[i] = int'(ref_in[i]);
            end
            if (auto_switch || !phase_ok) m_q = 0;
            else if (m_q < Q) m_q++;
            qual = (m_q == Q);
            drop = m_locked && !phase_ok;
            if (auto_switch || qual) m_t = 0;
            else if (m_t < TM) m_t++;
            tout = !auto_switch && !qual && (m_t >= TM);
            if (qual) m_lol = 0;
            else if (tout) m_lol = 1;
            else if (drop && !(m_mask || auto_switch)) m_lol = 1;
            m_locked = phase_ok && (m_locked || qual);
            if (auto_switch) m_mask = 1;
            else if (qual || tout) m_mask = 0;
            if (hist_flush) begin m_avail = 0; m_built = 0; end
            else if (hist_done) begin m_avail = 1; m_built = 1; end
            else if (hist_start) m_built = 0;
        end
        armed = 1;
    end

    // Cycle-by-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (armed) begin
            logic [7:0] exp_s;
            exp_s = {3'b000, m_built, m_avail, m_locked, m_lol, m_los[ref_sel]};
            checks++;
            if (status !== exp_s) begin
                failures++;
                if (status[0] !== exp_s[0]) $display("FAIL R2/R3 los t=%0t actual=%b expected=%b", $time, status[0], exp_s[0]);
                if (status[1] !== exp_s[1]) $display("FAIL R6/R7/R9 lol t=%0t actual=%b expected=%b", $time, status[1], exp_s[1]);
                if (status[2] !== exp_s[2]) $display("FAIL R4/R5 locked t=%0t actual=%b expected=%b", $time, status[2], exp_s[2]);
                if (status[3] !== exp_s[3]) $display("FAIL R10 avail t=%0t actual=%b expected=%b", $time, status[3], exp_s[3]);
                if (status[4] !== exp_s[4]) $display("FAIL R11/R12 built t=%0t actual=%b expected=%b", $time, status[4], exp_s[4]);
                if (status[7:5] !== 3'b000) $display("FAIL R1 rsvd t=%0t actual=%b expected=000", $time, status[7:5]);
            end
        end
    end

    task automatic chk(input string tag, input logic actual, input logic expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s t=%0t actual=%b expected=%b", tag, $time, actual, expected);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1;
            cyc++;
            auto_switch = 1'b0;
            hist_start = 1'b0; hist_done = 1'b0; hist_flush = 1'b0;
            for (int i = 0; i < 4; i++)
                ref_in[i] = (hp[i] == 0) ? 1'b0 : 1'(((cyc / hp[i]) % 2));
        end
    endtask

    task automatic at_neg();
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(3);
        at_neg();
        checks++;
        if (status !== 8'h00) begin
            failures++;
            $display("FAIL R1 reset actual=%h expected=00", status);
        end
        rst = 1'b0;
        // Loss of signal per reference, no lock
        tick(TM);
        at_neg(); chk("R7 timeout", status[1], 1'b1);
        chk("R2 active ref", status[0], 1'b0);
        ref_sel = 2'd2; #1;
        chk("R3 idle ref", status[0], 1'b1);
        ref_sel = 2'd0;
        // Qualification and lock drop
        phase_ok = 1'b1;
        tick(Q - 1); at_neg(); chk("R4 not yet", status[2], 1'b0);
        tick(1); at_neg(); chk("R4 locked", status[2], 1'b1);
        chk("R8 lol cleared", status[1], 1'b0);
        phase_ok = 1'b0;
        tick(1); at_neg(); chk("R5 unlocked", status[2], 1'b0);
        chk("R6 lol on drop", status[1], 1'b1);
        // Switch coinciding with a drop
        phase_ok = 1'b1; tick(Q);
        auto_switch = 1'b1; phase_ok = 1'b0;
        tick(1); at_neg(); chk("R9 masked drop", status[1], 1'b0);
        phase_ok = 1'b1; tick(Q); at_neg(); chk("R4 relock", status[2], 1'b1);
        auto_switch = 1'b1;
        tick(1); at_neg(); chk("R9 lock kept", status[2], 1'b1);
        tick(Q);
        phase_ok = 1'b0;
        tick(1); at_neg(); chk("R6 unmasked drop", status[1], 1'b1);
        // Switch then timeout
        phase_ok = 1'b1; tick(Q);
        auto_switch = 1'b1; phase_ok = 1'b0;
        tick(1);
        tick(TM - 1); at_neg(); chk("R9 masked window", status[1], 1'b0);
        tick(1); at_neg(); chk("R7 timeout after switch", status[1], 1'b1);
        // Holdover flags
        hist_done = 1'b1; tick(1); at_neg();
        chk("R10 avail", status[3], 1'b1); chk("R11 built", status[4], 1'b1);
        hist_start = 1'b1; tick(1); at_neg();
        chk("R11 start clears", status[4], 1'b0); chk("R10 avail kept", status[3], 1'b1);
        hist_start = 1'b1; hist_done = 1'b1; tick(1); at_neg();
        chk("R11 done wins", status[4], 1'b1);
        hist_flush = 1'b1; hist_done = 1'b1; tick(1); at_neg();
        chk("R12 flush avail", status[3], 1'b0); chk("R12 flush built", status[4], 1'b0);
        // Random traffic, checked every cycle against the model
        void'($urandom(11));
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 8) phase_ok = ~phase_ok;
            if (r == 50 || r == 51) auto_switch = 1'b1;
            if (r == 60) hist_start = 1'b1;
            if (r == 61) hist_done = 1'b1;
            if (r == 62) hist_flush = 1'b1;
            if (r == 63) begin hist_done = 1'b1; hist_start = 1'b1; end
            if (r == 70) ref_sel = 2'($urandom_range(0, 3));
            if (r == 71) hp[$urandom_range(0, 3)] = int'($urandom_range(0, 9));
            if (r == 72) hp[$urandom_range(0, 3)] = int'($urandom_range(10, 16));
            tick(1);
        end
        at_neg();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule